// File: doc/BRIEF.md
# Video Fetch A12 Pattern Generator

This block is a stimulus source that replays, cycle by cycle, the level of pattern-address bit 12 as a video fetch engine drives it across one whole frame. The pattern modelled is the common arrangement in which background tiles are read from the lower pattern table and sprite tiles from the upper one. A bench or a cartridge-logic model uses it to feed a scanline-counting interrupt circuit with the same edges that real rendering produces.

Everything runs from one master clock. A six-step tick sequence yields a pixel-clock enable on every second tick and a processor-cycle strobe on two fixed ticks of the six. Each pixel enable moves a dot counter across 341 positions per line and a line counter across 262 lines per frame. A12 is decoded from the fetch phase of the current dot and line. Within the sprite window it follows an eight-dot rhythm: four low dots for dummy tile-map fetches, then four high dots for sprite pattern fetches. The block also reports the dot, the line, the strobe and a blanking flag.

Top module: `a12_frame_gen`

## Requirements
- R1: A synchronous reset gives dot 0, line 0, A12 low, blanking flag low and the processor strobe high, which marks position 0 of the six-clock sequence.
- R2: After reset, the dot advances by one on each clock edge taken at sequence positions 0, 2 and 4, so it advances once every two master clocks.
- R3: The processor strobe is high at sequence positions 0 and 3 and low at positions 1, 2, 4 and 5.
- R4: The dot counts 0 to 340. The advance past 340 gives dot 0 and increments the line.
- R5: The line counts 0 to 261. The advance past line 261 dot 340 gives line 0 dot 0.
- R6: On lines 240 to 260, A12 is low at every dot.
- R7: On all other lines, A12 is low at dots 0 to 256 and at dots 321 to 340.
- R8: On all other lines, A12 is high at dots 257 to 320 when dot mod 8 is 5, 6, 7 or 0. It is low there when dot mod 8 is 1, 2, 3 or 4.
- R9: The blanking flag is high exactly while the line is 240 to 260.
- R10: A12 always matches the dot and line shown beside it. It changes only in the same clock as a dot advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| a12 | output | 1 | Modelled pattern-address bit 12 |
| dot | output | 9 | Current dot within the line, 0 to 340 |
| line | output | 9 | Current line within the frame, 0 to 261 |
| cpu_stb | output | 1 | High during master clocks that carry a processor cycle |
| vblank | output | 1 | High on the blanking lines 240 to 260 |

## Verification
The hardest situation to reach is the frame wrap, from line 261 dot 340 back to line 0. The lines that border the blanking interval must be crossed on the way. The block has no input except reset, so those conditions come only after about 178,000 master clocks. The stimulus runs one full frame without a break. It checks every clock inside the windows of interest and skips ahead, without checking, between them. The check windows cover line 0, a sprite window on a middle line, and the stretch from line 239 through the wrap. A reset in mid-run then shows that the tick sequence and both counters restart together.

// File: rtl/a12_gen_pkg.sv
package a12_gen_pkg;

  // Fetch activity that owns the pattern bus at a given dot
  typedef enum logic [1:0] {
    FETCH_BG       = 2'd0,  // background tile work, low table
    FETCH_SPR_MAP  = 2'd1,  // dummy tile-map reads inside sprite window
    FETCH_SPR_TILE = 2'd2,  // sprite pattern reads, high table
    FETCH_IDLE     = 2'd3   // blanking, bus parked low
  } fetch_e;

endpackage

// File: rtl/a12_tick_seq.sv
module a12_tick_seq #(
  parameter int SEQ_LEN  = 6,
  parameter int PPU_DIV  = 2,
  parameter int CPU_PH_A = 0,
  parameter int CPU_PH_B = 3
) (
  input  logic clk,
  input  logic rst,
  output logic ppu_en,
  output logic cpu_stb
);
  localparam int TW = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1;
  localparam logic [TW-1:0] LAST = TW'(SEQ_LEN - 1);

  logic [TW-1:0] tick;

  always_ff @(posedge clk) begin
    if (rst)               tick <= '0;
    else if (tick == LAST) tick <= '0;
    else                   tick <= tick + 1'b1;
  end

  // Pixel enable: a mask when the divider is a power of two, a modulo otherwise
  generate
    if ((PPU_DIV & (PPU_DIV - 1)) == 0) begin : g_mask
      assign ppu_en = (tick & TW'(PPU_DIV - 1)) == '0;
    end else begin : g_mod
      assign ppu_en = ((32'(tick)) % PPU_DIV) == 0;
    end
  endgenerate

  assign cpu_stb = (tick == TW'(CPU_PH_A)) || (tick == TW'(CPU_PH_B));

endmodule

// File: rtl/a12_raster_ctr.sv
module a12_raster_ctr #(
  parameter int DOTS  = 341,
  parameter int LINES = 262,
  localparam int DW = $clog2(DOTS),
  localparam int LW = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ppu_en,
  output logic [DW-1:0] dot,
  output logic [LW-1:0] line,
  output logic [DW-1:0] nxt_dot,
  output logic [LW-1:0] nxt_line
);
  localparam logic [DW-1:0] DOT_LAST  = DW'(DOTS - 1);
  localparam logic [LW-1:0] LINE_LAST = LW'(LINES - 1);

  always_comb begin
    nxt_dot  = dot;
    nxt_line = line;
    if (ppu_en) begin
      if (dot == DOT_LAST) begin
        nxt_dot  = '0;
        nxt_line = (line == LINE_LAST) ? '0 : line + 1'b1;
      end else begin
        nxt_dot = dot + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dot  <= '0;
      line <= '0;
    end else begin
      dot  <= nxt_dot;
      line <= nxt_line;
    end
  end

endmodule

// File: rtl/a12_phase_dec.sv
module a12_phase_dec
  import a12_gen_pkg::*;
#(
  parameter int DOTS      = 341,
  parameter int LINES     = 262,
  parameter int VBL_FIRST = 240,
  parameter int VBL_LAST  = 260,
  parameter int SPR_FIRST = 257,
  parameter int SPR_LAST  = 320,
  parameter int SLOT_LOG2 = 3,
  localparam int DW = $clog2(DOTS),
  localparam int LW = $clog2(LINES)
) (
  input  logic [DW-1:0] dot,
  input  logic [LW-1:0] line,
  output fetch_e        phase,
  output logic          in_vbl
);
  localparam logic [SLOT_LOG2-1:0] SPR_PH = SLOT_LOG2'(SPR_FIRST);

  logic                 in_spr;
  logic [SLOT_LOG2-1:0] slot_pos;

  assign in_vbl   = (line >= LW'(VBL_FIRST)) && (line <= LW'(VBL_LAST));
  assign in_spr   = (dot >= DW'(SPR_FIRST)) && (dot <= DW'(SPR_LAST));
  // Position inside the current sprite slot, 0 at the slot's first dot
  assign slot_pos = dot[SLOT_LOG2-1:0] - SPR_PH;

  always_comb begin
    if (in_vbl)                        phase = FETCH_IDLE;
    else if (!in_spr)                  phase = FETCH_BG;
    else if (slot_pos[SLOT_LOG2-1])    phase = FETCH_SPR_TILE;
    else                               phase = FETCH_SPR_MAP;
  end

endmodule

// File: rtl/a12_drive.sv
module a12_drive
  import a12_gen_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   ppu_en,
  input  fetch_e phase,
  input  logic   in_vbl,
  output logic   a12,
  output logic   vblank
);
  always_ff @(posedge clk) begin
    if (rst) begin
      a12    <= 1'b0;
      vblank <= 1'b0;
    end else if (ppu_en) begin
      a12    <= (phase == FETCH_SPR_TILE);
      vblank <= in_vbl;
    end
  end

endmodule

// File: rtl/a12_frame_gen.sv
module a12_frame_gen
  import a12_gen_pkg::*;
#(
  parameter int SEQ_LEN   = 6,
  parameter int PPU_DIV   = 2,
  parameter int CPU_PH_A  = 0,
  parameter int CPU_PH_B  = 3,
  parameter int DOTS      = 341,
  parameter int LINES     = 262,
  parameter int VBL_FIRST = 240,
  parameter int VBL_LAST  = 260,
  parameter int SPR_FIRST = 257,
  parameter int SPR_LAST  = 320,
  parameter int SLOT_LOG2 = 3,
  localparam int DW = $clog2(DOTS),
  localparam int LW = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst,
  output logic          a12,
  output logic [DW-1:0] dot,
  output logic [LW-1:0] line,
  output logic          cpu_stb,
  output logic          vblank
);
  logic          ppu_en;
  logic [DW-1:0] nxt_dot;
  logic [LW-1:0] nxt_line;
  fetch_e        nxt_phase;
  logic          nxt_vbl;

  a12_tick_seq #(
    .SEQ_LEN(SEQ_LEN), .PPU_DIV(PPU_DIV),
    .CPU_PH_A(CPU_PH_A), .CPU_PH_B(CPU_PH_B)
  ) u_tick (
    .clk(clk), .rst(rst), .ppu_en(ppu_en), .cpu_stb(cpu_stb)
  );

  a12_raster_ctr #(.DOTS(DOTS), .LINES(LINES)) u_raster (
    .clk(clk), .rst(rst), .ppu_en(ppu_en),
    .dot(dot), .line(line), .nxt_dot(nxt_dot), .nxt_line(nxt_line)
  );

  // Decode the position the counters move to, so the registered A12
  // lines up with the dot and line shown beside it
  a12_phase_dec #(
    .DOTS(DOTS), .LINES(LINES), .VBL_FIRST(VBL_FIRST), .VBL_LAST(VBL_LAST),
    .SPR_FIRST(SPR_FIRST), .SPR_LAST(SPR_LAST), .SLOT_LOG2(SLOT_LOG2)
  ) u_dec (
    .dot(nxt_dot), .line(nxt_line), .phase(nxt_phase), .in_vbl(nxt_vbl)
  );

  a12_drive u_drive (
    .clk(clk), .rst(rst), .ppu_en(ppu_en),
    .phase(nxt_phase), .in_vbl(nxt_vbl), .a12(a12), .vblank(vblank)
  );

endmodule

// File: rtl/a12_frame_gen_chk.sv
module a12_frame_gen_chk #(
  parameter int DOTS      = 341,
  parameter int LINES     = 262,
  parameter int VBL_FIRST = 240,
  parameter int VBL_LAST  = 260,
  parameter int SPR_FIRST = 257,
  parameter int SPR_LAST  = 320,
  localparam int DW = $clog2(DOTS),
  localparam int LW = $clog2(LINES)
) (
  input logic          clk,
  input logic          rst,
  input logic          ppu_en,
  input logic          a12,
  input logic [DW-1:0] dot,
  input logic [LW-1:0] line,
  input logic          cpu_stb,
  input logic          vblank
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  AST_A12_HOLDS_OFF_PIXEL: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(ppu_en)) |-> ($stable(a12) && $stable(dot))); // R10

  AST_CPU_NOT_ADJACENT: assert property (@(posedge clk) disable iff (rst)
    cpu_stb |=> !cpu_stb); // R3

  AST_DOT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    dot <= DW'(DOTS - 1)); // R4

  AST_DOT_WRAPS: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(ppu_en) && $past(dot) == DW'(DOTS - 1)) |-> (dot == '0)); // R4

  AST_LINE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    line <= LW'(LINES - 1)); // R5

  AST_BLANK_A12_LOW: assert property (@(posedge clk) disable iff (rst)
    vblank |-> !a12); // R6

  AST_BG_A12_LOW: assert property (@(posedge clk) disable iff (rst)
    (dot < DW'(SPR_FIRST) || dot > DW'(SPR_LAST)) |-> !a12); // R7

  AST_BLANK_FLAG_LINES: assert property (@(posedge clk) disable iff (rst)
    vblank |-> (line >= LW'(VBL_FIRST) && line <= LW'(VBL_LAST))); // R9

endmodule

bind a12_frame_gen a12_frame_gen_chk #(
  .DOTS(DOTS), .LINES(LINES), .VBL_FIRST(VBL_FIRST), .VBL_LAST(VBL_LAST),
  .SPR_FIRST(SPR_FIRST), .SPR_LAST(SPR_LAST)
) u_chk (
  .clk(clk), .rst(rst), .ppu_en(ppu_en), .a12(a12), .dot(dot),
  .line(line), .cpu_stb(cpu_stb), .vblank(vblank)
);

// File: tb/a12_frame_gen_test.sv
module a12_frame_gen_test;
  localparam int NDOT  = 341;
  localparam int NLINE = 262;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       a12;
  logic [8:0] dot;
  logic [8:0] line;
  logic       cpu_stb;
  logic       vblank;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic prev_a12 = 1'b0;

  always #2 clk = ~clk;

  a12_frame_gen uut (
    .clk(clk), .rst(rst), .a12(a12), .dot(dot), .line(line),
    .cpu_stb(cpu_stb), .vblank(vblank)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic int exp_a12(input int ln, input int d);
    if (ln >= 240 && ln <= 260) return 0;
    if (d >= 257 && d <= 320) return ((d % 8) >= 5 || (d % 8) == 0) ? 1 : 0;
    return 0;
  endfunction

  // Compare every output with the position implied by the clocks since reset
  task automatic check_now();
    int p, ed, el, pos;
    string areq;
    p   = (cyc + 1) / 2;
    ed  = p % NDOT;
    el  = (p / NDOT) % NLINE;
    pos = cyc % 6;
    chk("R2/R4", "dot", int'(dot), ed);
    chk("R5", "line", int'(line), el);
    chk("R3", "cpu_stb", int'(cpu_stb), (pos == 0 || pos == 3) ? 1 : 0);
    chk("R9", "vblank", int'(vblank), (el >= 240 && el <= 260) ? 1 : 0);
    if (el >= 240 && el <= 260)      areq = "R6";
    else if (ed >= 257 && ed <= 320) areq = "R8";
    else                             areq = "R7";
    chk(areq, "a12", int'(a12), exp_a12(el, ed));
    if (cyc > 0 && (cyc % 2) == 0)
      chk("R10", "a12 held between pixel edges", int'(a12), int'(prev_a12));
    prev_a12 = a12;
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
  endtask

  task automatic skip_to(input int target);
    while ((cyc + 1) / 2 < target) step();
  endtask

  task automatic check_to(input int target);
    while ((cyc + 1) / 2 < target) begin
      step();
      check_now();
    end
  endtask

  task automatic check_reset_state();
    chk("R1", "dot", int'(dot), 0);
    chk("R1", "line", int'(line), 0);
    chk("R1", "a12", int'(a12), 0);
    chk("R1", "vblank", int'(vblank), 0);
    chk("R1", "cpu_stb", int'(cpu_stb), 1);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check_reset_state();
    rst = 1'b0;
    cyc = 0;
    prev_a12 = 1'b0;
    check_now();
  endtask

  // R2 R3: first four sequences, every clock
  task automatic t_strobes();
    for (int i = 0; i < 24; i++) begin
      step();
      check_now();
    end
  endtask

  // R4 R7: all of line 0 and across into line 1
  task automatic t_line0();
    check_to(NDOT + 4);
  endtask

  // R8: sprite window of a middle line
  task automatic t_sprite_line();
    skip_to(100 * NDOT + 250);
    check_to(100 * NDOT + 330);
  endtask

  // R6 R9 R5: through blanking, pre-render line and the frame wrap
  task automatic t_blank_and_wrap();
    skip_to(239 * NDOT + 330);
    check_to(NLINE * NDOT + 8);
  endtask

  // R1: reset in mid-run restarts sequence and counters
  task automatic t_midrun_reset();
    skip_to(NLINE * NDOT + 300);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check_reset_state();
    rst = 1'b0;
    cyc = 0;
    prev_a12 = 1'b0;
    check_now();
    for (int i = 0; i < 12; i++) begin
      step();
      check_now();
    end
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired before the scenarios ended");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_strobes();
    t_line0();
    t_sprite_line();
    t_blank_and_wrap();
    t_midrun_reset();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule